// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates one 32-bit effective address through a segmented, hashed page table held in memory. The requester supplies the address, the access kind (load, store or instruction fetch), the privilege state, the segment register already selected by the top four address bits, and the table base register. The walker derives a protection key, hashes the segment's virtual segment identifier with the page index, and scans a group of eight two-word table entries. If no entry in that group matches, it scans a second group found with the complemented hash.

On a permitted match the walker sets the referenced bit, and for a store also the changed bit, in the entry's second word. It writes that word back only when a bit actually changed. It returns the real page number, read/write permission and a status. Write permission is left out of the reported permissions while the changed bit is still clear, so that the first store to the page faults again and gets its changed bit recorded. The memory port is a plain 32-bit word port with one cycle of read latency. The response is held until it is acknowledged.

Top module: `hpt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0.
- R2: A request is taken only while req_ready is 1. rsp_valid and all response fields stay constant until rsp_ack is seen, and req_ready is 1 again in the cycle after the acknowledge.
- R3: When segment bit 31 is set, the walker answers with status 4 (direct-store, unsupported) and makes no memory access.
- R4: An instruction fetch whose segment has bit 28 set gets status 3 (no-execute) with no memory access. Bit 28 has no effect on data accesses, or on fetches when it is clear.
- R5: The identifier is seg[23:0] and the page index is ea[27:12]. The first hash is ((identifier XOR index) AND 0x7FFFF) << 6. The mask is (base[8:0] << 16) OR 0xFFC0. The group address is (base AND 0xFFFF0000) OR (hash AND mask). Entry i occupies words at group+8i (word 0) and group+8i+4 (word 1). Read data arrives one cycle after the read request.
- R6: An entry matches when word 0 bit 31 is 1, word 0 bit 6 equals the hash-select bit of the current pass, and word 0 with bits 31 and 6 cleared equals (identifier << 7) OR (index >> 10).
- R7: The second pass uses the hash (NOT first hash) AND 0x01FFFFC0 with hash-select 1. It runs only when the first pass found no match at all.
- R8: The key is 1 when the access is in user state with seg[29] set, or in supervisor state with seg[30] set. Otherwise it is 0.
- R9: The PP field is word 1 bits 1..0. Key 0: PP 0, 1 and 2 give read+write, and PP 3 gives read only. Key 1: PP 0 gives nothing, PP 1 and PP 3 give read only, and PP 2 gives read+write. An access lacking its right returns status 2 (protection).
- R10: A permitted access returns status 0 with rsp_rpn equal to word 1 bits 31..12 of the first matching entry.
- R11: On status 0 the walker sets word 1 bit 8, and bit 7 too for a store, and writes word 1 back only if its value changed. rsp_perm_w is 1 only when the PP grants write and bit 7 is set after the update.
- R12: If two matching entries of one group differ in word 1 under mask 0xFFFFF07B, the status is 2.
- R13: With no match in either pass, the status is 1 (miss). For every status other than 0, rsp_rpn, rsp_perm_r and rsp_perm_w are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | 1 = store access |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_user | input | 1 | 1 = user state, 0 = supervisor |
| req_seg | input | 32 | Segment register for this address |
| req_base | input | 32 | Page table base and size register |
| rsp_valid | output | 1 | Response present |
| rsp_ack | input | 1 | Response consumed |
| rsp_status | output | 3 | 0 hit, 1 miss, 2 protection, 3 no-execute, 4 direct-store |
| rsp_rpn | output | 20 | Real page number |
| rsp_perm_r | output | 1 | Read permitted |
| rsp_perm_w | output | 1 | Write permitted |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |

## Verification
The bench builds page tables in a model memory at group addresses computed from the hashing rules. It then asks for translations that hit in the first group, hit only in the second group behind a first-group entry with the wrong hash-select bit, or miss everywhere. These cases separate a correct hash, mask and pass order from a swapped or skipped one. Every key and PP combination that matters is tried with both loads and stores. The resulting entry word is read back to tell apart a correct referenced/changed update, an update that is missing, and a write-back that should not happen. Duplicate matches that agree or disagree, a nonzero table-size mask, and direct-store and no-execute segments check the fault paths. The acknowledge delay varies, so the response hold rule is checked as well.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    localparam int WORD_W     = 32;
    localparam int RPN_W      = 20;
    localparam int VSID_W     = 24;
    localparam int PIDX_W     = 16;
    localparam int HASH_W     = 19;

    localparam int SEG_DIRECT_BIT = 31;
    localparam int SEG_KEY_SUP    = 30;
    localparam int SEG_KEY_USR    = 29;
    localparam int SEG_NOEXEC_BIT = 28;

    localparam int PTE_VALID_BIT  = 31;
    localparam int PTE_HSEL_BIT   = 6;
    localparam int PTE_REF_BIT    = 8;
    localparam int PTE_CHG_BIT    = 7;

    localparam logic [WORD_W-1:0] CMP_MASK     = 32'h7FFF_FFBF;
    localparam logic [WORD_W-1:0] CONSIST_MASK = 32'hFFFF_F07B;
    localparam logic [WORD_W-1:0] ALT_HASH_KEEP = 32'h01FF_FFC0;

    typedef enum logic [2:0] {
        XS_HIT    = 3'd0,
        XS_MISS   = 3'd1,
        XS_PROT   = 3'd2,
        XS_NOEXEC = 3'd3,
        XS_DIRECT = 3'd4
    } xlat_status_e;

    typedef enum logic [2:0] {
        W_IDLE, W_RD0, W_RD1, W_CHK, W_END, W_WB, W_RSP
    } walk_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } perm_t;

    function automatic perm_t pp_grant(input logic key, input logic [1:0] pp);
        perm_t p;
        if (!key) begin
            p.rd = 1'b1;
            p.wr = (pp != 2'd3);
        end else begin
            unique case (pp)
                2'd0:    p = '{rd: 1'b0, wr: 1'b0};
                2'd2:    p = '{rd: 1'b1, wr: 1'b1};
                default: p = '{rd: 1'b1, wr: 1'b0};
            endcase
        end
        return p;
    endfunction
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
(
    input  logic [WORD_W-1:0] seg,
    input  logic [WORD_W-1:0] ea,
    input  logic [WORD_W-1:0] base,
    input  logic              hsel,
    input  logic              user,
    output logic              key,
    output logic [WORD_W-1:0] group_addr,
    output logic [WORD_W-1:0] cmp_val
);
    logic [VSID_W-1:0] vsid;
    logic [PIDX_W-1:0] pidx;
    logic [HASH_W-1:0] mix;
    logic [WORD_W-1:0] h_first, h_sel, tbl_mask;

    always_comb begin
        vsid     = seg[VSID_W-1:0];
        pidx     = ea[27:12];
        mix      = vsid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, pidx};
        h_first  = {7'b0, mix, 6'b0};
        h_sel    = hsel ? (~h_first & ALT_HASH_KEEP) : h_first;
        tbl_mask = {7'b0, base[8:0], 16'hFFC0};
        group_addr = {base[31:16], 16'h0000} | (h_sel & tbl_mask);
        cmp_val  = {1'b0, vsid, 1'b0, pidx[15:10]};
        key      = (seg[SEG_KEY_USR] & user) | (seg[SEG_KEY_SUP] & ~user);
    end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
    import hpt_pkg::*;
(
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] cmp_val,
    input  logic              hsel,
    output logic              hit
);
    always_comb begin
        hit = w0[PTE_VALID_BIT] && (w0[PTE_HSEL_BIT] == hsel) &&
              ((w0 & CMP_MASK) == cmp_val);
    end
endmodule

// File: rtl/hpt_perm.sv
module hpt_perm
    import hpt_pkg::*;
(
    input  logic       key,
    input  logic [1:0] pp,
    output perm_t      perm
);
    always_comb perm = pp_grant(key, pp);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_ea,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              req_user,
    input  logic [WORD_W-1:0] req_seg,
    input  logic [WORD_W-1:0] req_base,
    output logic              rsp_valid,
    input  logic              rsp_ack,
    output logic [2:0]        rsp_status,
    output logic [RPN_W-1:0]  rsp_rpn,
    output logic              rsp_perm_r,
    output logic              rsp_perm_w,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int IDX_W = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

    walk_state_e       state;
    logic [WORD_W-1:0] ea_q, seg_q, base_q, keep_q, wb_q;
    logic              wr_q, user_q, sel_q, found_q, conflict_q;
    logic [IDX_W-1:0]  idx_q, good_q;
    xlat_status_e      status_q;
    logic [RPN_W-1:0]  rpn_q;
    logic              pr_q, pw_q;

    logic              key;
    logic [WORD_W-1:0] group_addr, cmp_val, entry_addr, upd_w1;
    logic              w0_hit, granted;
    perm_t             perm;

    hpt_hash u_hash (
        .seg(seg_q), .ea(ea_q), .base(base_q), .hsel(sel_q), .user(user_q),
        .key(key), .group_addr(group_addr), .cmp_val(cmp_val)
    );

    hpt_match u_match (
        .w0(mem_rdata), .cmp_val(cmp_val), .hsel(sel_q), .hit(w0_hit)
    );

    hpt_perm u_perm (
        .key(key), .pp(keep_q[1:0]), .perm(perm)
    );

    always_comb begin
        entry_addr = group_addr | (WORD_W'(idx_q) << 3);
        granted    = wr_q ? perm.wr : perm.rd;
        upd_w1     = keep_q | (WORD_W'(1) << PTE_REF_BIT) |
                     (wr_q ? (WORD_W'(1) << PTE_CHG_BIT) : '0);
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            W_RD0: begin
                mem_req  = 1'b1;
                mem_addr = entry_addr;
            end
            W_RD1: begin
                mem_req  = w0_hit;
                mem_addr = entry_addr | 32'h4;
            end
            W_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = group_addr | (WORD_W'(good_q) << 3) | 32'h4;
                mem_wdata = wb_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= W_IDLE;
            ea_q       <= '0;
            seg_q      <= '0;
            base_q     <= '0;
            keep_q     <= '0;
            wb_q       <= '0;
            wr_q       <= 1'b0;
            user_q     <= 1'b0;
            sel_q      <= 1'b0;
            found_q    <= 1'b0;
            conflict_q <= 1'b0;
            idx_q      <= '0;
            good_q     <= '0;
            status_q   <= XS_MISS;
            rpn_q      <= '0;
            pr_q       <= 1'b0;
            pw_q       <= 1'b0;
        end else begin
            unique case (state)
                W_IDLE: if (req_valid) begin
                    ea_q       <= req_ea;
                    seg_q      <= req_seg;
                    base_q     <= req_base;
                    wr_q       <= req_write;
                    user_q     <= req_user;
                    sel_q      <= 1'b0;
                    idx_q      <= '0;
                    found_q    <= 1'b0;
                    conflict_q <= 1'b0;
                    rpn_q      <= '0;
                    pr_q       <= 1'b0;
                    pw_q       <= 1'b0;
                    if (req_seg[SEG_DIRECT_BIT]) begin
                        status_q <= XS_DIRECT;
                        state    <= W_RSP;
                    end else if (req_fetch && req_seg[SEG_NOEXEC_BIT]) begin
                        status_q <= XS_NOEXEC;
                        state    <= W_RSP;
                    end else begin
                        state    <= W_RD0;
                    end
                end
                W_RD0: state <= W_RD1;
                W_RD1: begin
                    if (w0_hit)                state <= W_CHK;
                    else if (idx_q == LAST_IDX) state <= W_END;
                    else begin
                        idx_q <= idx_q + 1'b1;
                        state <= W_RD0;
                    end
                end
                W_CHK: begin
                    if (!found_q) begin
                        found_q <= 1'b1;
                        keep_q  <= mem_rdata;
                        good_q  <= idx_q;
                    end else if ((mem_rdata & CONSIST_MASK) != (keep_q & CONSIST_MASK)) begin
                        conflict_q <= 1'b1;
                    end
                    if (idx_q == LAST_IDX) state <= W_END;
                    else begin
                        idx_q <= idx_q + 1'b1;
                        state <= W_RD0;
                    end
                end
                W_END: begin
                    if (!found_q) begin
                        if (!sel_q) begin
                            sel_q <= 1'b1;
                            idx_q <= '0;
                            state <= W_RD0;
                        end else begin
                            status_q <= XS_MISS;
                            state    <= W_RSP;
                        end
                    end else if (conflict_q || !granted) begin
                        status_q <= XS_PROT;
                        state    <= W_RSP;
                    end else begin
                        status_q <= XS_HIT;
                        rpn_q    <= keep_q[WORD_W-1:WORD_W-RPN_W];
                        pr_q     <= perm.rd;
                        pw_q     <= perm.wr & upd_w1[PTE_CHG_BIT];
                        wb_q     <= upd_w1;
                        state    <= (upd_w1 != keep_q) ? W_WB : W_RSP;
                    end
                end
                W_WB:  state <= W_RSP;
                W_RSP: if (rsp_ack) state <= W_IDLE;
                default: state <= W_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == W_IDLE);
    assign rsp_valid  = (state == W_RSP);
    assign rsp_status = status_q;
    assign rsp_rpn    = rpn_q;
    assign rsp_perm_r = pr_q;
    assign rsp_perm_w = pw_q;

    // R2
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_status) &&
                                  $stable(rsp_rpn) && $stable(rsp_perm_w));

    // R2
    mem_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready || rsp_valid) |-> !mem_req);

    // R11
    wb_word1_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_addr[2:0] == 3'b100 && mem_wdata[PTE_REF_BIT]);

    // R13
    nohit_perm_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_status != 3'(XS_HIT) |-> !rsp_perm_r && !rsp_perm_w && rsp_rpn == '0);

    // R11
    store_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_status == 3'(XS_HIT) && wr_q |-> rsp_perm_w && rsp_perm_r);

    // R3
    direct_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready && req_valid && req_seg[SEG_DIRECT_BIT] |=>
            rsp_valid && rsp_status == 3'(XS_DIRECT));
endmodule

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
    logic [31:0] req_ea = '0, req_seg = '0, req_base = '0;
    logic        req_ready, rsp_valid, rsp_perm_r, rsp_perm_w;
    logic        rsp_ack = 1'b0;
    logic [2:0]  rsp_status;
    logic [19:0] rsp_rpn;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    hpt_walker dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ea(req_ea), .req_write(req_write), .req_fetch(req_fetch),
        .req_user(req_user), .req_seg(req_seg), .req_base(req_base),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_status(rsp_status),
        .rsp_rpn(rsp_rpn), .rsp_perm_r(rsp_perm_r), .rsp_perm_w(rsp_perm_w),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // model memory, one-cycle read latency
    logic [31:0] mem [int unsigned];
    int mem_ops = 0;
    always @(posedge clk) begin
        if (mem_req) begin
            mem_ops = mem_ops + 1;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end
    end

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    int checks = 0, errors = 0;
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // group address and word 0 built from the R5/R6 formulas
    function automatic logic [31:0] grp(input logic [31:0] seg, ea, base, input logic sel);
        logic [31:0] h, m;
        h = (((32'(seg[23:0]) ^ 32'(ea[27:12])) & 32'h7FFFF) << 6);
        if (sel) h = ~h & 32'h01FFFFC0;
        m = (32'(base[8:0]) << 16) | 32'hFFC0;
        return (base & 32'hFFFF0000) | (h & m);
    endfunction
    function automatic logic [31:0] w0of(input logic [31:0] seg, ea, input logic sel);
        return 32'h80000000 | (32'(seg[23:0]) << 7) | (32'(sel) << 6) | 32'(ea[27:22]);
    endfunction
    task automatic put(input logic [31:0] g, input int i, input logic [31:0] w0, w1);
        mem[g + 32'(i * 8)]     = w0;
        mem[g + 32'(i * 8) + 4] = w1;
    endtask

    typedef struct {
        string       req;
        logic [2:0]  st;
        logic [19:0] rpn;
        logic        pr, pw;
        logic [31:0] ca, cw;
        bit          no_mem;
        int          ops0;
    } exp_t;
    exp_t sb[$];
    int issued = 0, done_cnt = 0;

    task automatic run(input string req, input logic [31:0] ea, input logic wr, fe, us,
                       input logic [31:0] seg, base, input logic [2:0] st,
                       input logic [19:0] rpn, input logic pr, pw,
                       input logic [31:0] ca, cw, input bit no_mem);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.req = req; e.st = st; e.rpn = rpn; e.pr = pr; e.pw = pw;
        e.ca = ca; e.cw = cw; e.no_mem = no_mem; e.ops0 = mem_ops;
        sb.push_back(e);
        issued++;
        req_valid = 1'b1; req_ea = ea; req_write = wr; req_fetch = fe;
        req_user = us; req_seg = seg; req_base = base;
        @(negedge clk);
        req_valid = 1'b0;
        wait (done_cnt == issued);
    endtask

    // monitor / scoreboard
    int hold_n = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                exp_t e;
                logic [2:0] st0;
                logic [19:0] rpn0;
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected response: actual %h expected none", rsp_status);
                end else begin
                    e = sb.pop_front();
                    chk(e.req, "status", 32'(rsp_status), 32'(e.st));
                    chk(e.req, "rpn", 32'(rsp_rpn), 32'(e.rpn));
                    chk(e.req, "perm_r", 32'(rsp_perm_r), 32'(e.pr));
                    chk(e.req, "perm_w", 32'(rsp_perm_w), 32'(e.pw));
                    if (e.ca != 0) chk(e.req, "entry word1", rdm(e.ca), e.cw);
                    if (e.no_mem) chk(e.req, "memory accesses", 32'(mem_ops), 32'(e.ops0));
                end
                st0 = rsp_status; rpn0 = rsp_rpn;
                for (int k = 0; k < hold_n; k++) begin
                    @(negedge clk);
                    chk("R2", "held response", {rsp_valid, 8'(st0), 20'(rpn0)},
                        {1'b1, 8'(rsp_status), 20'(rsp_rpn)});
                end
                rsp_ack = 1'b1;
                @(negedge clk);
                rsp_ack = 1'b0;
                chk("R2", "ready after ack", {31'b0, req_ready}, 32'h1);
                hold_n = (hold_n + 1) % 4;
                done_cnt++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [31:0] B0  = 32'h0040_0000;
    localparam logic [31:0] B1  = 32'h0040_0003;
    localparam logic [31:0] EA  = 32'h3ABC_D123;
    localparam logic [31:0] SK0 = 32'h0012_3456;
    localparam logic [31:0] SKU = 32'h2012_3456;
    localparam logic [31:0] SKS = 32'h4012_3456;
    localparam logic [31:0] SNX = 32'h1012_3456;
    localparam logic [31:0] SDS = 32'h8012_3456;

    initial begin
        logic [31:0] g0, g1, gb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1", "reset ready", {31'b0, req_ready}, 32'h1);
        chk("R1", "reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R1", "reset mem_req", {31'b0, mem_req}, 32'h0);

        g0 = grp(SK0, EA, B0, 1'b0);
        g1 = grp(SK0, EA, B0, 1'b1);

        // R5 R10 R11: primary hit at slot 3, load withholds write
        mem.delete();
        put(g0, 3, w0of(SK0, EA, 1'b0), 32'hCAFE_B002);
        run("R10", EA, 0, 0, 0, SK0, B0, 3'd0, 20'hCAFEB, 1, 0, g0 + 28, 32'hCAFE_B102, 0);
        // R11: first store sets changed bit
        run("R11", EA, 1, 0, 0, SK0, B0, 3'd0, 20'hCAFEB, 1, 1, g0 + 28, 32'hCAFE_B182, 0);
        // R11: store with bits already set leaves word alone
        run("R11", EA, 1, 0, 0, SK0, B0, 3'd0, 20'hCAFEB, 1, 1, g0 + 28, 32'hCAFE_B182, 0);

        // R6 R7: primary entry has wrong hash-select; secondary slot 7 hits
        mem.delete();
        put(g0, 0, w0of(SK0, EA, 1'b1), 32'h7777_7002);
        put(g1, 7, w0of(SK0, EA, 1'b1), 32'h1234_5002);
        run("R7", EA, 0, 0, 0, SK0, B0, 3'd0, 20'h12345, 1, 0, g1 + 60, 32'h1234_5102, 0);
        chk("R6", "skipped primary word1", rdm(g0 + 4), 32'h7777_7002);

        // R13: empty tables
        mem.delete();
        run("R13", EA, 0, 0, 0, SK0, B0, 3'd1, 20'h0, 0, 0, 0, 0, 0);

        // R8 R9: key 1 (user, seg bit 29)
        mem.delete();
        put(g0, 0, w0of(SK0, EA, 1'b0), 32'h00AB_C000);
        run("R9", EA, 0, 0, 1, SKU, B0, 3'd2, 20'h0, 0, 0, g0 + 4, 32'h00AB_C000, 0);
        // R8: same segment in supervisor state is key 0, PP 0 read+write
        run("R8", EA, 0, 0, 0, SKU, B0, 3'd0, 20'h00ABC, 1, 0, g0 + 4, 32'h00AB_C100, 0);
        put(g0, 0, w0of(SK0, EA, 1'b0), 32'h00AB_C001);
        run("R9", EA, 0, 0, 1, SKU, B0, 3'd0, 20'h00ABC, 1, 0, g0 + 4, 32'h00AB_C101, 0);
        run("R9", EA, 1, 0, 1, SKU, B0, 3'd2, 20'h0, 0, 0, g0 + 4, 32'h00AB_C101, 0);
        // R8: supervisor with seg bit 30 is key 1, PP 2 read+write
        put(g0, 0, w0of(SK0, EA, 1'b0), 32'h00AB_C002);
        run("R8", EA, 1, 0, 0, SKS, B0, 3'd0, 20'h00ABC, 1, 1, g0 + 4, 32'h00AB_C182, 0);
        // R9: key 0 with PP 3 is read only
        put(g0, 0, w0of(SK0, EA, 1'b0), 32'h00AB_C003);
        run("R9", EA, 1, 0, 1, SK0, B0, 3'd2, 20'h0, 0, 0, g0 + 4, 32'h00AB_C003, 0);
        run("R9", EA, 0, 0, 1, SK0, B0, 3'd0, 20'h00ABC, 1, 0, g0 + 4, 32'h00AB_C103, 0);

        // R3: direct-store segment
        run("R3", EA, 0, 0, 0, SDS, B0, 3'd4, 20'h0, 0, 0, 0, 0, 1);
        // R4: no-execute fetch, then data access through same segment
        mem.delete();
        put(g0, 2, w0of(SNX, EA, 1'b0), 32'h4444_4002);
        run("R4", EA, 0, 1, 0, SNX, B0, 3'd3, 20'h0, 0, 0, g0 + 20, 32'h4444_4002, 1);
        run("R4", EA, 0, 0, 0, SNX, B0, 3'd0, 20'h44444, 1, 0, g0 + 20, 32'h4444_4102, 0);

        // R12: two matches with different page numbers
        mem.delete();
        put(g0, 1, w0of(SK0, EA, 1'b0), 32'h1111_1002);
        put(g0, 5, w0of(SK0, EA, 1'b0), 32'h2222_2002);
        run("R12", EA, 0, 0, 0, SK0, B0, 3'd2, 20'h0, 0, 0, g0 + 12, 32'h1111_1002, 0);
        // R12: matches differing only in the referenced bit agree; first one kept
        mem.delete();
        put(g0, 1, w0of(SK0, EA, 1'b0), 32'h3333_3002);
        put(g0, 5, w0of(SK0, EA, 1'b0), 32'h3333_3102);
        run("R12", EA, 0, 0, 0, SK0, B0, 3'd0, 20'h33333, 1, 0, g0 + 12, 32'h3333_3102, 0);

        // R5: nonzero size mask widens the hash; R4: fetch allowed with bit 28 clear
        gb = grp(SK0, EA, B1, 1'b0);
        chk("R5", "mask changes group", {31'b0, gb != g0}, 32'h1);
        mem.delete();
        put(gb, 2, w0of(SK0, EA, 1'b0), 32'h5555_5002);
        put(g0, 2, w0of(SK0, EA, 1'b0), 32'h6666_6002);
        run("R5", EA, 0, 1, 0, SK0, B1, 3'd0, 20'h55555, 1, 0, gb + 20, 32'h5555_5102, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule